// File: doc/BRIEF.md
# Flash Command and Status Sequencer

This block sits behind the bus front end of a firmware flash device and turns the byte writes it receives into flash commands. It keeps track of what a read returns: array contents, the status byte, or identifier bytes. It sequences the two-cycle program and sector-erase commands. When a command is accepted it issues a one-cycle request to the array model, and it holds the ready line low until a done pulse arrives from the timer that models the array.

The status byte has one ready bit and three sticky error flags. The flags are set only by the sequencer, when a command is malformed or targets a protected sector. They are cleared only by the dedicated clear command. A malformed erase sequence is reported by setting two flags together.

States: `ST_RD_ARRAY` (reads return array data; state after reset), `ST_RD_STATUS` (reads return the status byte), `ST_RD_ID` (reads return identifier bytes), `ST_PROG_ARM` (program armed, waiting for the address/data write), `ST_ERASE_ARM` (erase armed, waiting for the confirm write), `ST_BUSY` (array operation running). Transitions, all on an accepted write unless noted:
- any read state to `ST_PROG_ARM` on 40H or 10H
- any read state to `ST_ERASE_ARM` on 20H
- any read state to `ST_RD_STATUS` on 70H
- any read state to `ST_RD_ID` on 90H
- any read state to `ST_RD_ARRAY` on FFH
- `ST_PROG_ARM` to `ST_BUSY` on any write to an unprotected sector
- `ST_PROG_ARM` to `ST_RD_STATUS` on any write to a protected sector
- `ST_ERASE_ARM` to `ST_BUSY` on D0H to an unprotected sector
- `ST_ERASE_ARM` to `ST_RD_STATUS` on D0H to a protected sector
- `ST_ERASE_ARM` to `ST_RD_ARRAY` on any other byte
- `ST_BUSY` to `ST_RD_STATUS` on the done pulse, which needs no write

Top module: `flash_cmd_fsm`

## Requirements
- R1: After reset the block is in array-read mode, `ready` is 1, `op_req` is 0, and all error flags are clear, so the status byte reads 80H.
- R2: A write of 40H or 10H followed by any write to an unprotected sector raises `op_req` for exactly one cycle after the second write, with `op_kind`=0 (program) and `op_addr`/`op_data` equal to that write's address and data. `ready` falls in the same cycle.
- R3: A write of 20H followed by a write of D0H to an unprotected sector raises `op_req` for one cycle with `op_kind`=1 (erase) and `op_addr` equal to the confirm address.
- R4: A write of 20H followed by any byte other than D0H sets status bits 5 and 4 together, issues no request, and returns to array-read mode.
- R5: A second program or erase cycle whose `sect_prot` is 1 sets status bit 1, issues no request, leaves `ready` at 1, and enters status-read mode.
- R6: While busy, `ready` and status bit 7 are 0 and every write is ignored. The cycle after `op_done` is sampled, `ready` is 1 and the block is in status-read mode.
- R7: After 70H, reads return the status byte: bit 7 ready, bit 5 and bit 4 the sequence-error flags, bit 1 the protection flag, all other bits 0.
- R8: A write of 50H clears bits 5, 4 and 1. No other command, including FFH, 70H and 90H, clears them.
- R9: After 90H, a read of address 0 returns 1FH, a read of address 1 returns EDH, and any other address returns 00H.
- R10: After FFH, reads return `arr_rd_data`.
- R11: A first-cycle byte that is not a recognised command leaves the read mode unchanged.
- R12: `rd_data` is registered: it updates on the edge that samples `rd_en` and holds its value while `rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe from the bus front end |
| wr_addr | input | AW (24) | Write byte address |
| wr_data | input | 8 | Write data / command byte |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | AW (24) | Read byte address |
| sect_prot | input | 1 | 1 when the sector at `wr_addr` is hardware-protected or locked |
| arr_rd_data | input | 8 | Array data for the current read address |
| op_done | input | 1 | One-cycle pulse when the array operation finishes |
| rd_data | output | 8 | Read data, valid the cycle after `rd_en` |
| op_req | output | 1 | One-cycle request to start an array operation |
| op_kind | output | 1 | 0 program, 1 sector erase |
| op_addr | output | AW (24) | Target address of the request |
| op_data | output | 8 | Program data of the request |
| ready | output | 1 | 1 ready, 0 while an array operation runs |

## Verification
The program path is exercised with both arming bytes, and the erase path with a correct confirm and with a wrong one. Together these separate the request path from the sequence-error path. Each second cycle is repeated with `sect_prot` high, which tells a refused operation apart from a launched one. Writes during busy, unknown first bytes and mode changes after an error show that the error flags and the read mode change only on the intended commands. Identifier reads at addresses 0, 1 and 2 separate the two fixed bytes from the default.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        ST_RD_ARRAY,
        ST_RD_STATUS,
        ST_RD_ID,
        ST_PROG_ARM,
        ST_ERASE_ARM,
        ST_BUSY
    } fsm_state_t;

    typedef enum logic [1:0] {
        SEL_ARRAY,
        SEL_STATUS,
        SEL_ID
    } rd_sel_t;

    localparam logic [7:0] CMD_PROG_A   = 8'h40;
    localparam logic [7:0] CMD_PROG_B   = 8'h10;
    localparam logic [7:0] CMD_ERASE    = 8'h20;
    localparam logic [7:0] CMD_CONFIRM  = 8'hD0;
    localparam logic [7:0] CMD_STATUS   = 8'h70;
    localparam logic [7:0] CMD_CLR_ERR  = 8'h50;
    localparam logic [7:0] CMD_IDENT    = 8'h90;
    localparam logic [7:0] CMD_ARRAY    = 8'hFF;

    localparam logic OPK_PROGRAM = 1'b0;
    localparam logic OPK_ERASE   = 1'b1;

endpackage

// File: rtl/fcsm_status_reg.sv
module fcsm_status_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_seq,
    input  logic       set_prot,
    input  logic       clr_err,
    input  logic       wsm_ready,
    output logic [2:0] err_flags,
    output logic [7:0] status_byte
);
    // err_flags: [2] seq-hi (bit5), [1] seq-lo (bit4), [0] protect (bit1)
    logic [2:0] err_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 3'b000;
        end else if (set_seq || set_prot) begin
            err_q <= err_q | {set_seq, set_seq, set_prot};
        end else if (clr_err) begin
            err_q <= 3'b000;
        end
    end

    assign err_flags   = err_q;
    assign status_byte = {wsm_ready, 1'b0, err_q[2], err_q[1], 2'b00, err_q[0], 1'b0};

endmodule

// File: rtl/fcsm_read_mux.sv
module fcsm_read_mux
    import flash_cmd_pkg::*;
#(
    parameter int          AW     = 24,
    parameter logic [7:0]  MFR_ID = 8'h1F,
    parameter logic [7:0]  DEV_ID = 8'hED
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    input  rd_sel_t       rd_sel,
    input  logic [7:0]    status_byte,
    input  logic [7:0]    arr_rd_data,
    output logic [7:0]    rd_data
);
    localparam logic [AW-1:0] ID_MFR_ADDR = AW'(0);
    localparam logic [AW-1:0] ID_DEV_ADDR = AW'(1);

    logic [7:0] id_byte;
    logic [7:0] rd_next;

    always_comb begin
        if (rd_addr == ID_MFR_ADDR)      id_byte = MFR_ID;
        else if (rd_addr == ID_DEV_ADDR) id_byte = DEV_ID;
        else                             id_byte = 8'h00;
    end

    always_comb begin
        unique case (rd_sel)
            SEL_ARRAY:  rd_next = arr_rd_data;
            SEL_ID:     rd_next = id_byte;
            default:    rd_next = status_byte;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= 8'h00;
        else if (rd_en) rd_data <= rd_next;
    end

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    input  logic          sect_prot,
    input  logic [7:0]    arr_rd_data,
    input  logic          op_done,
    output logic [7:0]    rd_data,
    output logic          op_req,
    output logic          op_kind,
    output logic [AW-1:0] op_addr,
    output logic [7:0]    op_data,
    output logic          ready
);
    fsm_state_t state_q, state_d;
    logic       set_seq, set_prot, clr_err;
    logic       launch, launch_kind;
    logic [2:0] err_flags;
    logic [7:0] status_byte;
    rd_sel_t    rd_sel;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RD_ARRAY;
        else        state_q <= state_d;
    end

    // Next state and per-cycle actions
    always_comb begin
        state_d     = state_q;
        set_seq     = 1'b0;
        set_prot    = 1'b0;
        clr_err     = 1'b0;
        launch      = 1'b0;
        launch_kind = OPK_PROGRAM;
        unique case (state_q)
            ST_RD_ARRAY, ST_RD_STATUS, ST_RD_ID: begin
                if (wr_en) begin
                    unique case (wr_data)
                        CMD_PROG_A, CMD_PROG_B: state_d = ST_PROG_ARM;
                        CMD_ERASE:              state_d = ST_ERASE_ARM;
                        CMD_STATUS:             state_d = ST_RD_STATUS;
                        CMD_IDENT:              state_d = ST_RD_ID;
                        CMD_ARRAY:              state_d = ST_RD_ARRAY;
                        CMD_CLR_ERR:            clr_err = 1'b1;
                        default:                state_d = state_q;
                    endcase
                end
            end
            ST_PROG_ARM: begin
                if (wr_en) begin
                    if (sect_prot) begin
                        set_prot = 1'b1;
                        state_d  = ST_RD_STATUS;
                    end else begin
                        launch      = 1'b1;
                        launch_kind = OPK_PROGRAM;
                        state_d     = ST_BUSY;
                    end
                end
            end
            ST_ERASE_ARM: begin
                if (wr_en) begin
                    if (wr_data != CMD_CONFIRM) begin
                        set_seq = 1'b1;
                        state_d = ST_RD_ARRAY;
                    end else if (sect_prot) begin
                        set_prot = 1'b1;
                        state_d  = ST_RD_STATUS;
                    end else begin
                        launch      = 1'b1;
                        launch_kind = OPK_ERASE;
                        state_d     = ST_BUSY;
                    end
                end
            end
            ST_BUSY: begin
                if (op_done) state_d = ST_RD_STATUS;
            end
            default: state_d = ST_RD_ARRAY;
        endcase
    end

    // Registered request outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_req  <= 1'b0;
            op_kind <= OPK_PROGRAM;
            op_addr <= '0;
            op_data <= 8'h00;
        end else begin
            op_req <= launch;
            if (launch) begin
                op_kind <= launch_kind;
                op_addr <= wr_addr;
                op_data <= wr_data;
            end
        end
    end

    assign ready = (state_q != ST_BUSY);

    always_comb begin
        unique case (state_q)
            ST_RD_ARRAY: rd_sel = SEL_ARRAY;
            ST_RD_ID:    rd_sel = SEL_ID;
            default:     rd_sel = SEL_STATUS;
        endcase
    end

    fcsm_status_reg u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_seq     (set_seq),
        .set_prot    (set_prot),
        .clr_err     (clr_err),
        .wsm_ready   (ready),
        .err_flags   (err_flags),
        .status_byte (status_byte)
    );

    fcsm_read_mux #(.AW(AW)) u_rdmux (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en       (rd_en),
        .rd_addr     (rd_addr),
        .rd_sel      (rd_sel),
        .status_byte (status_byte),
        .arr_rd_data (arr_rd_data),
        .rd_data     (rd_data)
    );

endmodule

// File: rtl/fcsm_checker.sv
module fcsm_checker #(
    parameter int AW = 24
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       rd_en,
    input logic       op_done,
    input logic [7:0] rd_data,
    input logic       op_req,
    input logic       ready,
    input logic [2:0] err_flags
);
    assert_req_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        op_req |=> !op_req);

    assert_req_from_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        op_req |-> $past(wr_en));

    assert_busy_on_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> op_req);

    assert_busy_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !op_done) |=> !ready);

    assert_done_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && op_done) |=> ready);

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_data == 8'h50) |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

    assert_seq_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        err_flags[2] == err_flags[1]);

    assert_rd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

bind flash_cmd_fsm fcsm_checker #(.AW(AW)) u_fcsm_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .op_done   (op_done),
    .rd_data   (rd_data),
    .op_req    (op_req),
    .ready     (ready),
    .err_flags (err_flags)
);

// File: tb/flash_cmd_fsm_bench.sv
module flash_cmd_fsm_bench;
    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = 8'h00;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          sect_prot = 1'b0;
    logic [7:0]    arr_rd_data = 8'h5A;
    logic          op_done = 1'b0;
    logic [7:0]    rd_data;
    logic          op_req;
    logic          op_kind;
    logic [AW-1:0] op_addr;
    logic [7:0]    op_data;
    logic          ready;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    flash_cmd_fsm #(.AW(AW)) u_flash_cmd_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .sect_prot(sect_prot), .arr_rd_data(arr_rd_data),
        .op_done(op_done), .rd_data(rd_data), .op_req(op_req), .op_kind(op_kind),
        .op_addr(op_addr), .op_data(op_data), .ready(ready)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 ready", 32'(ready), 32'd1);
        check("R1 op_req", 32'(op_req), 32'd0);
        do_read(24'h000100, d);
        check("R1 array mode", 32'(d), 32'h5A);
        do_write(24'h0, 8'h70);
        do_read(24'h0, d);
        check("R1 status clear", 32'(d), 32'h80);
    endtask

    task automatic t_program(input logic [7:0] arm);
        logic [7:0] d;
        do_write(24'h0, 8'hFF);
        do_write(24'h0, arm);
        check("R2 no req on arm", 32'(op_req), 32'd0);
        do_write(24'h012345, 8'hA5);
        check("R2 op_req", 32'(op_req), 32'd1);
        check("R2 op_kind", 32'(op_kind), 32'd0);
        check("R2 op_addr", 32'(op_addr), 32'h012345);
        check("R2 op_data", 32'(op_data), 32'hA5);
        check("R2 ready low", 32'(ready), 32'd0);
        @(negedge clk);
        check("R2 single pulse", 32'(op_req), 32'd0);
        do_read(24'h0, d);
        check("R6 busy status", 32'(d), 32'h00);
        do_write(24'h0, 8'hFF);
        do_write(24'h0, 8'h40);
        check("R6 write ignored", 32'(op_req), 32'd0);
        check("R6 still busy", 32'(ready), 32'd0);
        pulse_done();
        check("R6 ready after done", 32'(ready), 32'd1);
        do_read(24'h0, d);
        check("R6 status mode after done", 32'(d), 32'h80);
    endtask

    task automatic t_erase();
        logic [7:0] d;
        do_write(24'h0, 8'h20);
        do_write(24'h031000, 8'hD0);
        check("R3 op_req", 32'(op_req), 32'd1);
        check("R3 op_kind", 32'(op_kind), 32'd1);
        check("R3 op_addr", 32'(op_addr), 32'h031000);
        pulse_done();
        do_read(24'h0, d);
        check("R3 done status", 32'(d), 32'h80);
    endtask

    task automatic t_erase_bad();
        logic [7:0] d;
        do_write(24'h0, 8'h20);
        do_write(24'h031000, 8'h33);
        check("R4 no req", 32'(op_req), 32'd0);
        check("R4 ready", 32'(ready), 32'd1);
        do_read(24'h000200, d);
        check("R4 array mode", 32'(d), 32'h5A);
        do_write(24'h0, 8'h70);
        do_read(24'h0, d);
        check("R4 R7 seq error bits", 32'(d), 32'hB0);
        do_write(24'h0, 8'hFF);
        do_write(24'h0, 8'h90);
        do_write(24'h0, 8'h70);
        do_read(24'h0, d);
        check("R8 sticky", 32'(d), 32'hB0);
        do_write(24'h0, 8'h50);
        do_read(24'h0, d);
        check("R8 cleared", 32'(d), 32'h80);
    endtask

    task automatic t_protect();
        logic [7:0] d;
        do_write(24'h0, 8'h40);
        sect_prot = 1'b1;
        do_write(24'h070010, 8'h12);
        check("R5 no prog req", 32'(op_req), 32'd0);
        check("R5 ready", 32'(ready), 32'd1);
        do_read(24'h0, d);
        check("R5 R7 prot bit", 32'(d), 32'h82);
        do_write(24'h0, 8'h20);
        do_write(24'h070000, 8'hD0);
        check("R5 no erase req", 32'(op_req), 32'd0);
        sect_prot = 1'b0;
        do_write(24'h0, 8'h50);
        do_read(24'h0, d);
        check("R8 prot cleared", 32'(d), 32'h80);
    endtask

    task automatic t_ident();
        logic [7:0] d;
        do_write(24'h0, 8'h90);
        do_read(24'h000000, d);
        check("R9 mfr", 32'(d), 32'h1F);
        do_read(24'h000001, d);
        check("R9 dev", 32'(d), 32'hED);
        do_read(24'h000002, d);
        check("R9 other", 32'(d), 32'h00);
        do_write(24'h0, 8'h77);
        do_read(24'h000001, d);
        check("R11 unknown keeps id", 32'(d), 32'hED);
        // R12: hold without rd_en
        @(negedge clk);
        rd_addr = 24'h000000;
        @(negedge clk);
        check("R12 hold", 32'(rd_data), 32'hED);
    endtask

    task automatic t_array();
        logic [7:0] d;
        do_write(24'h0, 8'hFF);
        arr_rd_data = 8'hC3;
        do_read(24'h004000, d);
        check("R10 array data", 32'(d), 32'hC3);
        do_write(24'h0, 8'hE5);
        do_read(24'h004000, d);
        check("R11 unknown keeps array", 32'(d), 32'hC3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program(8'h40);
        t_program(8'h10);
        t_erase();
        t_erase_bad();
        t_protect();
        t_ident();
        t_array();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule